// File: doc/BRIEF.md
# Timeslot Type Lookup Sequencer

This block classifies every timeslot of a TDM serial frame. A host fills a packed table that holds a 2-bit type code for each timeslot, writing one 32-bit word at a time. Each word covers sixteen timeslots. The frame-timing logic supplies a frame-start pulse and a strobe for each timeslot. For each strobe the block presents the type code of that timeslot together with four one-hot flags: unassigned, HDLC, voice and 56K. Downstream logic uses these to route the serial bits.

The line mode sets how many timeslots a frame holds, and so how many table words must be loaded before the table takes effect. Until every word the current mode needs has been written, each timeslot reads as unassigned.

Table words arrive on a valid/ready port. `wr_ready` is held high at all times, because a word lands in a register on the cycle it is offered, so the host never sees back-pressure. A word transfers on any clock edge where `wr_valid` is high. The frame-timing and mode pins are plain level or pulse controls.

Top module: `tslot_classifier`

## Requirements
- R1: The type codes are 00 = unassigned, 01 = HDLC, 10 = 56K and 11 = voice. Exactly one of `is_unassigned`, `is_hdlc`, `is_56k`, `is_voice` is high, and it matches `ts_type`.
- R2: After `load_start`, the first accepted word fills table position 1, which holds timeslots 0–15. Each following word fills the next position, up to position 8, which holds timeslots 112–127.
- R3: Within a word, timeslot k (0–15) of that word sits in data bits [31-2k : 30-2k]. Timeslot 0 is in bits 31:30 and timeslot 15 is in bits 1:0.
- R4: A word offered after position 8 has been filled is not stored. It sets `load_error`, which stays high until reset.
- R5: `line_mode` sets the frame length: 00 = 32 timeslots, 01 = 64, 10 = 128 and 11 = 128. The presented index is the internal count masked to the mode length, and the count wraps to 0 after the last timeslot.
- R6: `frame_start` restarts the count at timeslot 0. A strobe in the same cycle as `frame_start` presents timeslot 0, and the next strobe presents timeslot 1.
- R7: `ts_type`, `ts_index` and the flags update on the clock edge at which a strobe is sampled, so they are visible one cycle after the strobe. Without a strobe they hold their values.
- R8: `table_ready` is high once the number of words written since the last `load_start` is at least 2 (mode 00), 4 (mode 01) or 8 (modes 10 and 11). While it is low, every strobe presents type 00.
- R9: `load_start` restarts loading at position 1 and withdraws the table, so `table_ready` goes low. A word offered in the same cycle as `load_start` is stored at position 1.
- R10: `wr_ready` is always high. A word is accepted on every edge where `wr_valid` is high.
- R11: Reset clears the outputs to timeslot 0 with type unassigned, and clears `load_error` and `table_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Pulse that restarts table loading at position 1 |
| wr_valid | input | 1 | Table word offered |
| wr_ready | output | 1 | Table word can be taken (always high) |
| wr_data | input | 32 | Table word: 16 two-bit codes, timeslot 0 in the MSBs |
| line_mode | input | 2 | 00 E1/T1, 01 dual MVIP, 10/11 quad MVIP |
| frame_start | input | 1 | Frame boundary pulse |
| ts_strobe | input | 1 | One pulse per timeslot |
| ts_type | output | 2 | Type code of the presented timeslot |
| ts_index | output | 7 | Index of the presented timeslot |
| is_unassigned | output | 1 | Presented timeslot is unassigned |
| is_hdlc | output | 1 | Presented timeslot carries HDLC |
| is_voice | output | 1 | Presented timeslot carries voice |
| is_56k | output | 1 | Presented timeslot is in 56K mode |
| table_ready | output | 1 | Enough words are loaded for the current mode |
| load_error | output | 1 | Sticky overflow of table writes |

## Verification
The bench sweeps every mode across its wrap point:
- A counter that wraps at the wrong limit shows up as index 32 in mode 00.
- Reversed bit pairs inside a word, or a word order that starts at the wrong position, give wrong codes in the first or last timeslots.

It also covers the load-control corner cases:
- A ninth write would corrupt position 8 if it were stored, or leave `load_error` low.
- A write in the same cycle as `load_start` would be lost if the restart took priority over it.
- A table that took effect after its first word would leak non-zero codes before loading is complete.

Finally, the bench shrinks the mode in the middle of a frame, which exposes a presented index that is not masked. It also raises `frame_start` together with a strobe, which exposes a strobe that presents timeslot 1 instead of 0.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

  typedef enum logic [1:0] {
    TS_UNASSIGNED = 2'b00,
    TS_HDLC       = 2'b01,
    TS_56K        = 2'b10,
    TS_VOICE      = 2'b11
  } ts_type_e;

  typedef enum logic [1:0] {
    MODE_E1T1  = 2'b00,
    MODE_DUAL  = 2'b01,
    MODE_QUAD  = 2'b10,
    MODE_QUADX = 2'b11
  } line_mode_e;

  // Number of table words a line mode needs, given the full table depth.
  function automatic int unsigned words_for_mode(input logic [1:0] mode,
                                                 input int unsigned total);
    case (mode)
      MODE_E1T1: return total / 4;
      MODE_DUAL: return total / 2;
      default:   return total;
    endcase
  endfunction

endpackage

// File: rtl/tslot_table_loader.sv
module tslot_table_loader #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned PTR_W     = $clog2(NUM_WORDS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_start,
  input  logic                          wr_valid,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic [1:0]                    line_mode,
  output logic [NUM_WORDS*WORD_W-1:0]   table_flat,
  output logic                          table_ready,
  output logic                          load_error
);
  import tslot_pkg::*;

  localparam logic [PTR_W-1:0] FULL = PTR_W'(NUM_WORDS);

  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] wr_slot;
  logic             wr_take;
  logic [PTR_W-1:0] need;

  // A write alongside load_start lands in position 1 (slot 0).
  assign wr_slot = load_start ? '0 : wptr;
  assign wr_take = wr_valid && (load_start || (wptr < FULL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
    end else if (load_start) begin
      wptr <= wr_valid ? PTR_W'(1) : '0;
    end else if (wr_take) begin
      wptr <= wptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_error <= 1'b0;
    end else if (wr_valid && !load_start && (wptr == FULL)) begin
      load_error <= 1'b1;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr_take && (wr_slot == PTR_W'(w))) begin
        word_q <= wr_data;
      end
    end
    assign table_flat[w*WORD_W +: WORD_W] = word_q;
  end

  assign need        = PTR_W'(words_for_mode(line_mode, NUM_WORDS));
  assign table_ready = (wptr >= need);

endmodule

// File: rtl/tslot_sequencer.sv
module tslot_sequencer #(
  parameter int unsigned NUM_WORDS      = 8,
  parameter int unsigned SLOTS_PER_WORD = 16,
  parameter int unsigned IDX_W          = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             ts_strobe,
  input  logic [1:0]       line_mode,
  output logic [IDX_W-1:0] present_idx
);
  import tslot_pkg::*;

  logic [IDX_W-1:0] next_idx;
  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] base;

  assign mask        = IDX_W'(words_for_mode(line_mode, NUM_WORDS) * SLOTS_PER_WORD - 1);
  assign base        = frame_start ? '0 : next_idx;
  assign present_idx = base & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_idx <= '0;
    end else if (ts_strobe) begin
      next_idx <= (present_idx + IDX_W'(1)) & mask;
    end else if (frame_start) begin
      next_idx <= '0;
    end
  end

endmodule

// File: rtl/tslot_type_decode.sv
module tslot_type_decode #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned TYPE_W    = 2,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned SLOT_BITS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NUM_WORDS*WORD_W-1:0] table_flat,
  input  logic                        table_ready,
  output logic [TYPE_W-1:0]           ts_type,
  output logic [IDX_W-1:0]            ts_index,
  output logic                        is_unassigned,
  output logic                        is_hdlc,
  output logic                        is_voice,
  output logic                        is_56k
);
  import tslot_pkg::*;

  logic [WORD_W-1:0]    words [NUM_WORDS];
  logic [WORD_W-1:0]    sel_word;
  logic [WORD_W-1:0]    shifted;
  logic [SLOT_BITS-1:0] pos;
  logic [TYPE_W-1:0]    type_next;
  logic [3:0]           flags_next;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_unpack
    assign words[w] = table_flat[w*WORD_W +: WORD_W];
  end

  assign sel_word  = words[idx[IDX_W-1:SLOT_BITS]];
  assign pos       = idx[SLOT_BITS-1:0];
  // Earlier timeslots sit in higher bit pairs: shift the wanted pair to the top.
  assign shifted   = sel_word << (int'(pos) * TYPE_W);
  assign type_next = table_ready ? shifted[WORD_W-1 -: TYPE_W] : '0;

  always_comb begin
    flags_next = 4'b0000;
    case (ts_type_e'(type_next))
      TS_HDLC:  flags_next[1] = 1'b1;
      TS_56K:   flags_next[2] = 1'b1;
      TS_VOICE: flags_next[3] = 1'b1;
      default:  flags_next[0] = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_type       <= '0;
      ts_index      <= '0;
      is_unassigned <= 1'b1;
      is_hdlc       <= 1'b0;
      is_56k        <= 1'b0;
      is_voice      <= 1'b0;
    end else if (fire) begin
      ts_type       <= type_next;
      ts_index      <= idx;
      is_unassigned <= flags_next[0];
      is_hdlc       <= flags_next[1];
      is_56k        <= flags_next[2];
      is_voice      <= flags_next[3];
    end
  end

endmodule

// File: rtl/tslot_classifier.sv
module tslot_classifier #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned TYPE_W    = 2,
  localparam int unsigned SLOTS_PER_WORD = WORD_W / TYPE_W,
  localparam int unsigned MAX_SLOTS      = NUM_WORDS * SLOTS_PER_WORD,
  localparam int unsigned IDX_W          = $clog2(MAX_SLOTS),
  localparam int unsigned SLOT_BITS      = $clog2(SLOTS_PER_WORD),
  localparam int unsigned PTR_W          = $clog2(NUM_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        line_mode,
  input  logic              frame_start,
  input  logic              ts_strobe,
  output logic [TYPE_W-1:0] ts_type,
  output logic [IDX_W-1:0]  ts_index,
  output logic              is_unassigned,
  output logic              is_hdlc,
  output logic              is_voice,
  output logic              is_56k,
  output logic              table_ready,
  output logic              load_error
);

  logic [NUM_WORDS*WORD_W-1:0] table_flat;
  logic [IDX_W-1:0]            present_idx;

  assign wr_ready = 1'b1;

  tslot_table_loader #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .PTR_W(PTR_W)
  ) u_loader (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .line_mode(line_mode), .table_flat(table_flat),
    .table_ready(table_ready), .load_error(load_error)
  );

  tslot_sequencer #(
    .NUM_WORDS(NUM_WORDS), .SLOTS_PER_WORD(SLOTS_PER_WORD), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ts_strobe(ts_strobe),
    .line_mode(line_mode), .present_idx(present_idx)
  );

  tslot_type_decode #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .TYPE_W(TYPE_W),
    .IDX_W(IDX_W), .SLOT_BITS(SLOT_BITS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .fire(ts_strobe), .idx(present_idx),
    .table_flat(table_flat), .table_ready(table_ready), .ts_type(ts_type),
    .ts_index(ts_index), .is_unassigned(is_unassigned), .is_hdlc(is_hdlc),
    .is_voice(is_voice), .is_56k(is_56k)
  );

endmodule

// File: rtl/tslot_classifier_chk.sv
module tslot_classifier_chk #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned IDX_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_start,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [1:0]       line_mode,
  input logic             frame_start,
  input logic             ts_strobe,
  input logic [1:0]       ts_type,
  input logic [IDX_W-1:0] ts_index,
  input logic             is_unassigned,
  input logic             is_hdlc,
  input logic             is_voice,
  input logic             is_56k,
  input logic             table_ready,
  input logic             load_error
);

  logic [7:0] limit;
  assign limit = (line_mode == 2'b00) ? 8'(NUM_WORDS * 4) :
                 (line_mode == 2'b01) ? 8'(NUM_WORDS * 8) : 8'(NUM_WORDS * 16);

  // R1
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({is_unassigned, is_hdlc, is_voice, is_56k}) == 1);

  // R1
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_voice == (ts_type == 2'b11)) && (is_hdlc == (ts_type == 2'b01)) &&
    (is_56k == (ts_type == 2'b10)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_strobe |=> $stable(ts_type) && $stable(ts_index));

  // R4
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_error |=> load_error);

  // R8
  unapplied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_strobe && !table_ready |=> ts_type == 2'b00);

  // R6
  frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_strobe && frame_start |=> ts_index == '0);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_start && !wr_valid |=> !table_ready);

  // R10
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);

  // R5
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_strobe |=> 8'(ts_index) < $past(limit));

endmodule

bind tslot_classifier tslot_classifier_chk #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_start(load_start), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .line_mode(line_mode), .frame_start(frame_start),
  .ts_strobe(ts_strobe), .ts_type(ts_type), .ts_index(ts_index),
  .is_unassigned(is_unassigned), .is_hdlc(is_hdlc), .is_voice(is_voice),
  .is_56k(is_56k), .table_ready(table_ready), .load_error(load_error)
);

// File: tb/tslot_classifier_test.sv
module tslot_classifier_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_start = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [1:0]  line_mode = 2'b00;
  logic        frame_start = 1'b0;
  logic        ts_strobe = 1'b0;
  logic [1:0]  ts_type;
  logic [6:0]  ts_index;
  logic        is_unassigned, is_hdlc, is_voice, is_56k;
  logic        table_ready, load_error;

  int checks = 0;
  int failures = 0;

  // bench model
  logic [31:0] m_words [8];
  int          m_wptr = 0;
  int          m_next = 0;
  logic [8:0]  exp_q [$];
  logic [8:0]  last_seen = '0;
  string       cur_req = "R3 R5";

  always #10 clk = ~clk;

  tslot_classifier uut (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .line_mode(line_mode),
    .frame_start(frame_start), .ts_strobe(ts_strobe), .ts_type(ts_type),
    .ts_index(ts_index), .is_unassigned(is_unassigned), .is_hdlc(is_hdlc),
    .is_voice(is_voice), .is_56k(is_56k), .table_ready(table_ready),
    .load_error(load_error)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int need(input logic [1:0] mode);
    return (mode == 2'b00) ? 2 : (mode == 2'b01) ? 4 : 8;
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'h1B93_E46C ^ {8{4'(i)}} ^ (32'h0000_0001 << (i * 3));
  endfunction

  // entry: at negedge
  task automatic write_word(input logic [31:0] d, input logic restart);
    wr_valid = 1'b1; wr_data = d; load_start = restart;
    if (restart) m_wptr = 0;
    if (m_wptr < 8) begin
      m_words[m_wptr] = d;
      m_wptr++;
    end
    @(negedge clk);
    wr_valid = 1'b0; load_start = 1'b0;
  endtask

  task automatic restart_load();
    load_start = 1'b1; m_wptr = 0;
    @(negedge clk);
    load_start = 1'b0;
  endtask

  // driver: strobe one timeslot, push expected result
  task automatic strobe(input logic fs, input int gap);
    int mask;
    int present;
    logic [1:0] t;
    mask = need(line_mode) * 16 - 1;
    present = (fs ? 0 : m_next) & mask;
    t = (m_wptr >= need(line_mode)) ? m_words[present / 16][31 - 2 * (present % 16) -: 2] : 2'b00;
    exp_q.push_back({7'(present), t});
    m_next = (present + 1) & mask;
    ts_strobe = 1'b1; frame_start = fs;
    @(negedge clk);
    ts_strobe = 1'b0; frame_start = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic frame_only();
    frame_start = 1'b1; m_next = 0;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // monitor: compares each strobe result one cycle later
  initial begin
    forever begin
      @(posedge clk);
      if (ts_strobe) begin
        logic [8:0] e;
        @(negedge clk);
        e = exp_q.pop_front();
        check({cur_req, " index"}, int'(ts_index), int'(e[8:2]));
        check({cur_req, " type"}, int'(ts_type), int'(e[1:0]));
        // R1 flags follow the type code
        check("R1 flags", int'({is_voice, is_56k, is_hdlc, is_unassigned}),
              (e[1:0] == 2'b00) ? 1 : (e[1:0] == 2'b01) ? 2 : (e[1:0] == 2'b10) ? 4 : 8);
        last_seen = {ts_index, ts_type};
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_words[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 type", int'(ts_type), 0);
    check("R11 index", int'(ts_index), 0);
    check("R11 unassigned", int'(is_unassigned), 1);
    check("R11 error", int'(load_error), 0);
    check("R11 ready", int'(table_ready), 0);
    check("R10 wr_ready", int'(wr_ready), 1);

    // E1/T1: one word is not enough (R8)
    line_mode = 2'b00;
    restart_load();
    write_word(pat(0), 1'b0);
    check("R8 ready after 1 word", int'(table_ready), 0);
    cur_req = "R8";
    strobe(1'b1, 0);
    for (int i = 0; i < 5; i++) strobe(1'b0, 0);
    write_word(pat(1), 1'b0);
    check("R8 ready after 2 words", int'(table_ready), 1);
    // R2 R3 R5 R6: sweep past the 32-slot wrap
    cur_req = "R2 R3 R5 R6";
    strobe(1'b1, 0);
    for (int i = 0; i < 40; i++) strobe(1'b0, 0);

    // dual: table withdrawn until 4 words
    line_mode = 2'b01;
    @(negedge clk);
    check("R8 dual not ready", int'(table_ready), 0);
    write_word(pat(2), 1'b0);
    write_word(pat(3), 1'b0);
    check("R8 dual ready", int'(table_ready), 1);
    cur_req = "R2 R5 R7";
    strobe(1'b1, 2);
    for (int i = 0; i < 70; i++) strobe(1'b0, i % 3);
    repeat (3) @(negedge clk);
    // R7 outputs hold without a strobe
    check("R7 hold", int'({ts_index, ts_type}), int'(last_seen));

    // quad
    line_mode = 2'b10;
    for (int i = 4; i < 8; i++) write_word(pat(i), 1'b0);
    check("R8 quad ready", int'(table_ready), 1);
    cur_req = "R2 R3 R5";
    strobe(1'b1, 0);
    for (int i = 0; i < 131; i++) strobe(1'b0, 0);

    // R4 overflow write ignored, sticky error
    write_word(32'hFFFF_FFFF, 1'b0);
    check("R4 error set", int'(load_error), 1);
    line_mode = 2'b11;
    cur_req = "R4 R5";
    strobe(1'b1, 0);
    for (int i = 0; i < 129; i++) strobe(1'b0, 0);

    // R5 mode shrink mid-frame masks the index
    frame_only();
    for (int i = 0; i < 50; i++) strobe(1'b0, 0);
    line_mode = 2'b00;
    cur_req = "R5 shrink";
    for (int i = 0; i < 20; i++) strobe(1'b0, 0);

    // R6 frame_start alone restarts at 0
    line_mode = 2'b10;
    for (int i = 0; i < 7; i++) strobe(1'b0, 0);
    frame_only();
    cur_req = "R6";
    strobe(1'b0, 0);
    strobe(1'b0, 0);

    // R9 restart withdraws table, error stays (R4)
    restart_load();
    check("R9 ready dropped", int'(table_ready), 0);
    check("R4 error sticky", int'(load_error), 1);
    cur_req = "R9";
    strobe(1'b1, 0);
    for (int i = 0; i < 4; i++) strobe(1'b0, 0);

    // R9 write alongside load_start lands at position 1
    write_word(32'h5555_AAAA, 1'b1);
    write_word(32'hC3C3_3C3C, 1'b0);
    line_mode = 2'b00;
    @(negedge clk);
    check("R9 ready with 2 words", int'(table_ready), 1);
    cur_req = "R9 R3";
    strobe(1'b1, 0);
    for (int i = 0; i < 33; i++) strobe(1'b0, 1);

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule